// File: doc/BRIEF.md
# Operand-Capturing Reservation Station Pool

This block is the scheduling window of a dynamically scheduled core. Renamed operations arrive on a dispatch port that is several slots wide. For each source, an operation carries either a value that is already known or the tag of the operation that will produce it. Each operation waits in a shared pool of entries. The pool watches a result broadcast bus: when a broadcast tag equals a source tag that is still pending, the broadcast value is copied into that source.

Entries are not kept in arrival order. An entry becomes a candidate as soon as both of its sources hold values. Each operation names the functional unit it needs. For every unit that is not busy, the pool picks one ready candidate, so up to one operation per unit leaves the pool in each cycle. A picked entry is released on the next clock edge. Dispatch works on whole groups: a group is taken only when enough free entries exist for every valid slot in it. A flush input empties the pool.

Top module: `rs_pool`

## Requirements
- R1: After reset the pool is empty: `free_cnt` equals NUM_ENTRIES, `full` is 0 and every `iss_vld` bit is 0.
- R2: `disp_ok` is 1 exactly when `free_cnt` is at least the number of set `in_vld` bits. `full` is 1 exactly when `free_cnt` is 0. A dispatch group is written only in a cycle where `disp_ok` is 1 and `flush` is 0, and otherwise it leaves the pool unchanged.
- R3: The valid slots of an accepted group fill the lowest-numbered free entries. The slot with the lowest index takes the lowest free entry, and invalid slots are skipped.
- R4: A source dispatched with its ready bit at 1 keeps the value it arrived with. A source dispatched with its ready bit at 0 waits for a broadcast of its tag.
- R5: When `bc_vld` is 1, every stored source that is still pending and whose tag equals `bc_tag` takes `bc_dat` and becomes ready on the next edge. A source that is already ready is not changed by a broadcast.
- R6: A source dispatched with its ready bit at 0, whose tag equals `bc_tag` in the same cycle while `bc_vld` is 1, is stored as ready and holds `bc_dat`.
- R7: An entry is issued on unit u only when it is valid, both of its sources are ready, its unit field equals u and `fu_busy[u]` is 0. The outputs for unit u then carry the entry's opcode, both source values and its destination tag.
- R8: When several entries qualify for the same unit, the entry with the lowest index is issued. Each unit is arbitrated on its own, so up to NUM_FU entries issue in one cycle regardless of the order in which they arrived.
- R9: An entry that is issued is free on the next edge. `free_cnt` rises by the number of issues, less the number of entries taken by dispatch.
- R10: In a cycle where `flush` is 1, no `iss_vld` bit is set and dispatch is ignored. On the next edge every entry is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clears every entry |
| in_vld | input | DISP_W | Per-slot valid of the dispatch group |
| in_op | input | DISP_W*OP_W | Opcode per slot |
| in_unit | input | DISP_W*UNIT_W | Functional unit index required per slot |
| in_s1_rdy | input | DISP_W | Source 1 holds a value |
| in_s1_tag | input | DISP_W*TAG_W | Source 1 producer tag |
| in_s1_dat | input | DISP_W*DATA_W | Source 1 value |
| in_s2_rdy | input | DISP_W | Source 2 holds a value |
| in_s2_tag | input | DISP_W*TAG_W | Source 2 producer tag |
| in_s2_dat | input | DISP_W*DATA_W | Source 2 value |
| in_dst | input | DISP_W*TAG_W | Destination tag per slot |
| disp_ok | output | 1 | Group fits and is taken when flush is 0 |
| free_cnt | output | CNT_W | Number of free entries |
| full | output | 1 | No free entry |
| bc_vld | input | 1 | Broadcast valid |
| bc_tag | input | TAG_W | Broadcast tag |
| bc_dat | input | DATA_W | Broadcast value |
| fu_busy | input | NUM_FU | Unit cannot accept an operation |
| iss_vld | output | NUM_FU | Operation issued to unit |
| iss_op | output | NUM_FU*OP_W | Issued opcode per unit |
| iss_s1 | output | NUM_FU*DATA_W | Issued source 1 value per unit |
| iss_s2 | output | NUM_FU*DATA_W | Issued source 2 value per unit |
| iss_dst | output | NUM_FU*TAG_W | Issued destination tag per unit |

## Verification
The bench builds the pool with NUM_ENTRIES = 6, DISP_W = 2 and NUM_FU = 3. With only six entries, a few two-slot groups fill the pool, so the full case and a group refused for lack of space come up often. With three units, several entries usually compete for the same unit, which exercises the lowest-index rule. The tag space is kept to eight values, so broadcasts often match pending sources, including sources that are written in the same cycle.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

    localparam int OP_W   = 6;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;
    localparam int UNIT_W = 3;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] dat;
    } rs_src_t;

    typedef struct packed {
        logic              vld;
        logic [OP_W-1:0]   op;
        logic [UNIT_W-1:0] unit;
        rs_src_t           s1;
        rs_src_t           s2;
        logic [TAG_W-1:0]  dst;
    } rs_entry_t;

    // Copy a broadcast value into a source that is still waiting on its tag.
    function automatic rs_src_t snoop(input rs_src_t s, input logic bv,
                                      input logic [TAG_W-1:0] bt,
                                      input logic [DATA_W-1:0] bd);
        rs_src_t r;
        r = s;
        if (!s.rdy && bv && (s.tag == bt)) begin
            r.rdy = 1'b1;
            r.dat = bd;
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_alloc.sv
// Finds the first K free entries (lowest index first) and counts the free ones.
module rs_alloc #(
    parameter int N = 20,
    parameter int K = 2,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
)(
    input  logic [N-1:0]            busy,
    output logic [K-1:0][IDX_W-1:0] pick,
    output logic [K-1:0]            pick_ok,
    output logic [CNT_W-1:0]        free_cnt
);

    logic [CNT_W-1:0] seen;

    always_comb begin
        seen    = '0;
        pick    = '0;
        pick_ok = '0;
        for (int e = 0; e < N; e++) begin
            if (!busy[e]) begin
                for (int k = 0; k < K; k++) begin
                    if (seen == CNT_W'(k)) begin
                        pick[k]    = IDX_W'(e);
                        pick_ok[k] = 1'b1;
                    end
                end
                seen = seen + 1'b1;
            end
        end
        free_cnt = seen;
    end

endmodule

// File: rtl/rs_pick.sv
// One fixed-priority picker per functional unit; the lowest index wins.
module rs_pick #(
    parameter int N = 20,
    parameter int NUM_FU = 6,
    localparam int IDX_W = $clog2(N)
)(
    input  logic [NUM_FU-1:0][N-1:0]     req,
    output logic [NUM_FU-1:0]            gnt_vld,
    output logic [NUM_FU-1:0][IDX_W-1:0] gnt_idx
);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        always_comb begin
            gnt_vld[u] = 1'b0;
            gnt_idx[u] = '0;
            for (int e = N - 1; e >= 0; e--) begin
                if (req[u][e]) begin
                    gnt_vld[u] = 1'b1;
                    gnt_idx[u] = IDX_W'(e);
                end
            end
        end
    end

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int NUM_ENTRIES = 20,
    parameter int DISP_W = 2,
    parameter int NUM_FU = 6,
    localparam int IDX_W = $clog2(NUM_ENTRIES),
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [DISP_W-1:0]              in_vld,
    input  logic [DISP_W-1:0][OP_W-1:0]    in_op,
    input  logic [DISP_W-1:0][UNIT_W-1:0]  in_unit,
    input  logic [DISP_W-1:0]              in_s1_rdy,
    input  logic [DISP_W-1:0][TAG_W-1:0]   in_s1_tag,
    input  logic [DISP_W-1:0][DATA_W-1:0]  in_s1_dat,
    input  logic [DISP_W-1:0]              in_s2_rdy,
    input  logic [DISP_W-1:0][TAG_W-1:0]   in_s2_tag,
    input  logic [DISP_W-1:0][DATA_W-1:0]  in_s2_dat,
    input  logic [DISP_W-1:0][TAG_W-1:0]   in_dst,
    output logic                           disp_ok,
    output logic [CNT_W-1:0]               free_cnt,
    output logic                           full,
    input  logic                           bc_vld,
    input  logic [TAG_W-1:0]               bc_tag,
    input  logic [DATA_W-1:0]              bc_dat,
    input  logic [NUM_FU-1:0]              fu_busy,
    output logic [NUM_FU-1:0]              iss_vld,
    output logic [NUM_FU-1:0][OP_W-1:0]    iss_op,
    output logic [NUM_FU-1:0][DATA_W-1:0]  iss_s1,
    output logic [NUM_FU-1:0][DATA_W-1:0]  iss_s2,
    output logic [NUM_FU-1:0][TAG_W-1:0]   iss_dst
);

    localparam int RK_W = $clog2(DISP_W + 1);

    typedef struct packed {
        rs_entry_t [NUM_ENTRIES-1:0] ent;
    } pool_state_t;

    pool_state_t state_q, state_d;

    // ---------------- occupancy and allocation ----------------
    logic [NUM_ENTRIES-1:0]         occ;
    logic [DISP_W-1:0][IDX_W-1:0]   pick;
    logic [DISP_W-1:0]              pick_ok;
    logic [CNT_W-1:0]               free_w;

    always_comb begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            occ[e] = state_q.ent[e].vld;
        end
    end

    rs_alloc #(
        .N (NUM_ENTRIES),
        .K (DISP_W)
    ) alloc_i (
        .busy     (occ),
        .pick     (pick),
        .pick_ok  (pick_ok),
        .free_cnt (free_w)
    );

    // Compact the valid slots onto consecutive free entries.
    logic [DISP_W-1:0][IDX_W-1:0] slot_idx;
    logic [DISP_W-1:0]            slot_has;
    logic [RK_W-1:0]              need;

    always_comb begin
        need     = '0;
        slot_idx = '0;
        slot_has = '0;
        for (int k = 0; k < DISP_W; k++) begin
            for (int j = 0; j < DISP_W; j++) begin
                if (need == RK_W'(j)) begin
                    slot_idx[k] = pick[j];
                    slot_has[k] = pick_ok[j];
                end
            end
            if (in_vld[k]) begin
                need = need + 1'b1;
            end
        end
    end

    assign disp_ok  = (free_w >= CNT_W'(need));
    assign free_cnt = free_w;
    assign full     = (free_w == '0);

    // ---------------- new entries with same-cycle snoop ----------------
    rs_entry_t [DISP_W-1:0] nw;

    always_comb begin
        for (int k = 0; k < DISP_W; k++) begin
            nw[k].vld  = 1'b1;
            nw[k].op   = in_op[k];
            nw[k].unit = in_unit[k];
            nw[k].s1   = snoop('{rdy: in_s1_rdy[k], tag: in_s1_tag[k], dat: in_s1_dat[k]},
                               bc_vld, bc_tag, bc_dat);
            nw[k].s2   = snoop('{rdy: in_s2_rdy[k], tag: in_s2_tag[k], dat: in_s2_dat[k]},
                               bc_vld, bc_tag, bc_dat);
            nw[k].dst  = in_dst[k];
        end
    end

    // ---------------- readiness and selection ----------------
    logic [NUM_FU-1:0][NUM_ENTRIES-1:0] req;
    logic [NUM_FU-1:0]                  gnt_vld;
    logic [NUM_FU-1:0][IDX_W-1:0]       gnt_idx;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                req[u][e] = state_q.ent[e].vld
                          && state_q.ent[e].s1.rdy
                          && state_q.ent[e].s2.rdy
                          && (state_q.ent[e].unit == UNIT_W'(u))
                          && !fu_busy[u]
                          && !flush;
            end
        end
    end

    rs_pick #(
        .N      (NUM_ENTRIES),
        .NUM_FU (NUM_FU)
    ) pick_i (
        .req     (req),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            iss_vld[u] = gnt_vld[u];
            iss_op[u]  = state_q.ent[gnt_idx[u]].op;
            iss_s1[u]  = state_q.ent[gnt_idx[u]].s1.dat;
            iss_s2[u]  = state_q.ent[gnt_idx[u]].s2.dat;
            iss_dst[u] = state_q.ent[gnt_idx[u]].dst;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            state_d.ent[e].s1 = snoop(state_q.ent[e].s1, bc_vld, bc_tag, bc_dat);
            state_d.ent[e].s2 = snoop(state_q.ent[e].s2, bc_vld, bc_tag, bc_dat);
        end
        for (int u = 0; u < NUM_FU; u++) begin
            if (gnt_vld[u]) begin
                state_d.ent[gnt_idx[u]].vld = 1'b0;
            end
        end
        if (disp_ok && !flush) begin
            for (int k = 0; k < DISP_W; k++) begin
                if (in_vld[k] && slot_has[k]) begin
                    state_d.ent[slot_idx[k]] = nw[k];
                end
            end
        end
        if (flush) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                state_d.ent[e].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
    parameter int NUM_ENTRIES = 20,
    parameter int DISP_W = 2,
    parameter int NUM_FU = 6,
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
)(
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [DISP_W-1:0] in_vld,
    input logic              disp_ok,
    input logic [CNT_W-1:0]  free_cnt,
    input logic              full,
    input logic [NUM_FU-1:0] fu_busy,
    input logic [NUM_FU-1:0] iss_vld
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (free_cnt == CNT_W'(NUM_ENTRIES)));                                     // R1

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && (in_vld != '0)) |-> !disp_ok);                                                    // R2

    AST_ACCEPT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && disp_ok && (iss_vld == '0))
        |=> (free_cnt == $past(free_cnt) - CNT_W'($countones($past(in_vld)))));                    // R3

    AST_BUSY_UNIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld & fu_busy) == '0);                                                                // R7

    AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (in_vld == '0) && (iss_vld != '0))
        |=> (free_cnt == $past(free_cnt) + CNT_W'($countones($past(iss_vld)))));                   // R9

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (iss_vld == '0));                                                                // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_cnt == CNT_W'(NUM_ENTRIES)));                                              // R10

endmodule

bind rs_pool rs_pool_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .DISP_W      (DISP_W),
    .NUM_FU      (NUM_FU)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_vld   (in_vld),
    .disp_ok  (disp_ok),
    .free_cnt (free_cnt),
    .full     (full),
    .fu_busy  (fu_busy),
    .iss_vld  (iss_vld)
);

// File: tb/rs_pool_tb_top.sv
`timescale 1ns/1ps
module rs_pool_tb_top;
    import rs_pool_pkg::*;

    localparam int N = 6;
    localparam int D = 2;
    localparam int F = 3;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush;
    logic [D-1:0]              in_vld;
    logic [D-1:0][OP_W-1:0]    in_op;
    logic [D-1:0][UNIT_W-1:0]  in_unit;
    logic [D-1:0]              in_s1_rdy;
    logic [D-1:0][TAG_W-1:0]   in_s1_tag;
    logic [D-1:0][DATA_W-1:0]  in_s1_dat;
    logic [D-1:0]              in_s2_rdy;
    logic [D-1:0][TAG_W-1:0]   in_s2_tag;
    logic [D-1:0][DATA_W-1:0]  in_s2_dat;
    logic [D-1:0][TAG_W-1:0]   in_dst;
    logic                      disp_ok;
    logic [CW-1:0]             free_cnt;
    logic                      full;
    logic                      bc_vld;
    logic [TAG_W-1:0]          bc_tag;
    logic [DATA_W-1:0]         bc_dat;
    logic [F-1:0]              fu_busy;
    logic [F-1:0]              iss_vld;
    logic [F-1:0][OP_W-1:0]    iss_op;
    logic [F-1:0][DATA_W-1:0]  iss_s1;
    logic [F-1:0][DATA_W-1:0]  iss_s2;
    logic [F-1:0][TAG_W-1:0]   iss_dst;

    always #10 clk = ~clk;

    rs_pool #(.NUM_ENTRIES(N), .DISP_W(D), .NUM_FU(F)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_vld(in_vld), .in_op(in_op), .in_unit(in_unit),
        .in_s1_rdy(in_s1_rdy), .in_s1_tag(in_s1_tag), .in_s1_dat(in_s1_dat),
        .in_s2_rdy(in_s2_rdy), .in_s2_tag(in_s2_tag), .in_s2_dat(in_s2_dat),
        .in_dst(in_dst), .disp_ok(disp_ok), .free_cnt(free_cnt), .full(full),
        .bc_vld(bc_vld), .bc_tag(bc_tag), .bc_dat(bc_dat), .fu_busy(fu_busy),
        .iss_vld(iss_vld), .iss_op(iss_op), .iss_s1(iss_s1), .iss_s2(iss_s2),
        .iss_dst(iss_dst)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Reference model of the pool contents
    bit                m_vld [N];
    logic [OP_W-1:0]   m_op  [N];
    logic [UNIT_W-1:0] m_unit[N];
    bit                m_r1  [N];
    logic [TAG_W-1:0]  m_t1  [N];
    logic [DATA_W-1:0] m_d1  [N];
    bit                m_r2  [N];
    logic [TAG_W-1:0]  m_t2  [N];
    logic [DATA_W-1:0] m_d2  [N];
    logic [TAG_W-1:0]  m_dst [N];

    task automatic chk(input string lbl, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", lbl, what, act, exp);
        end
    endtask

    task automatic clr_in();
        flush = 0; in_vld = '0; in_op = '0; in_unit = '0;
        in_s1_rdy = '0; in_s1_tag = '0; in_s1_dat = '0;
        in_s2_rdy = '0; in_s2_tag = '0; in_s2_dat = '0;
        in_dst = '0; bc_vld = 0; bc_tag = '0; bc_dat = '0; fu_busy = '0;
    endtask

    task automatic set_slot(input int k, input int op, input int unit,
                            input bit r1, input int t1, input logic [31:0] d1,
                            input bit r2, input int t2, input logic [31:0] d2,
                            input int dst);
        in_vld[k] = 1'b1; in_op[k] = OP_W'(op); in_unit[k] = UNIT_W'(unit);
        in_s1_rdy[k] = r1; in_s1_tag[k] = TAG_W'(t1); in_s1_dat[k] = d1;
        in_s2_rdy[k] = r2; in_s2_tag[k] = TAG_W'(t2); in_s2_dat[k] = d2;
        in_dst[k] = TAG_W'(dst);
    endtask

    // Inputs are driven just after a falling edge; check, advance the model, move to next falling edge.
    task automatic step(input string lbl);
        int free_n, need, c, fl[N];
        bit eok, eiv[F];
        int eidx[F];
        #2;
        free_n = 0;
        for (int e = 0; e < N; e++) if (!m_vld[e]) begin fl[free_n] = e; free_n++; end
        need = 0;
        for (int k = 0; k < D; k++) if (in_vld[k]) need++;
        eok = (free_n >= need);
        chk(lbl, "disp_ok (R2)", {127'b0, disp_ok}, {127'b0, eok});
        chk(lbl, "free_cnt (R2 R9)", 128'(free_cnt), 128'(free_n));
        chk(lbl, "full (R2)", {127'b0, full}, {127'b0, (free_n == 0)});
        for (int u = 0; u < F; u++) begin
            eiv[u] = 0; eidx[u] = 0;
            if (!flush && !fu_busy[u]) begin
                for (int e = N - 1; e >= 0; e--) begin
                    if (m_vld[e] && m_r1[e] && m_r2[e] && (m_unit[e] == UNIT_W'(u))) begin
                        eiv[u] = 1; eidx[u] = e;
                    end
                end
            end
            chk(lbl, $sformatf("iss_vld[%0d] (R7 R8)", u), {127'b0, iss_vld[u]}, {127'b0, eiv[u]});
            if (eiv[u]) begin
                chk(lbl, $sformatf("issue payload unit %0d (R7 R8)", u),
                    128'({iss_op[u], iss_s1[u], iss_s2[u], iss_dst[u]}),
                    128'({m_op[eidx[u]], m_d1[eidx[u]], m_d2[eidx[u]], m_dst[eidx[u]]}));
            end
        end
        // model update
        for (int u = 0; u < F; u++) if (eiv[u]) m_vld[eidx[u]] = 0;
        for (int e = 0; e < N; e++) begin
            if (bc_vld && !m_r1[e] && m_t1[e] == bc_tag) begin m_r1[e] = 1; m_d1[e] = bc_dat; end
            if (bc_vld && !m_r2[e] && m_t2[e] == bc_tag) begin m_r2[e] = 1; m_d2[e] = bc_dat; end
        end
        if (eok && !flush) begin
            c = 0;
            for (int k = 0; k < D; k++) begin
                if (in_vld[k]) begin
                    int e;
                    e = fl[c]; c++;
                    m_vld[e] = 1; m_op[e] = in_op[k]; m_unit[e] = in_unit[k];
                    m_r1[e] = in_s1_rdy[k]; m_t1[e] = in_s1_tag[k]; m_d1[e] = in_s1_dat[k];
                    m_r2[e] = in_s2_rdy[k]; m_t2[e] = in_s2_tag[k]; m_d2[e] = in_s2_dat[k];
                    m_dst[e] = in_dst[k];
                    if (bc_vld && !m_r1[e] && m_t1[e] == bc_tag) begin m_r1[e] = 1; m_d1[e] = bc_dat; end
                    if (bc_vld && !m_r2[e] && m_t2[e] == bc_tag) begin m_r2[e] = 1; m_d2[e] = bc_dat; end
                end
            end
        end
        if (flush) for (int e = 0; e < N; e++) m_vld[e] = 0;
        @(posedge clk);
        @(negedge clk);
        clr_in();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int e = 0; e < N; e++) begin
            m_vld[e] = 0; m_r1[e] = 0; m_r2[e] = 0;
            m_op[e] = '0; m_unit[e] = '0; m_t1[e] = '0; m_t2[e] = '0;
            m_d1[e] = '0; m_d2[e] = '0; m_dst[e] = '0;
        end
        clr_in();
        repeat (3) @(negedge clk);
        chk("R1", "free_cnt in reset", 128'(free_cnt), 128'(N));
        chk("R1", "iss_vld in reset", 128'(iss_vld), 128'(0));
        rst_n = 1'b1;
        step("R1");

        // R4: operands as values, issue next cycle on unit 1
        set_slot(0, 5, 1, 1, 0, 32'hA5A5_0001, 1, 0, 32'h5A5A_0002, 9);
        step("R4");
        step("R4");

        // R3 / R2: fill the pool with ops waiting on tag 5
        for (int g = 0; g < 3; g++) begin
            set_slot(0, 10 + 2 * g, (2 * g) % F, 0, 5, 32'hDEAD, 1, 0, 32'h100 + 2 * g, 20 + 2 * g);
            set_slot(1, 11 + 2 * g, (2 * g + 1) % F, 0, 5, 32'hBEEF, 1, 0, 32'h101 + 2 * g, 21 + 2 * g);
            step("R3");
        end
        chk("R2", "full after fill", {127'b0, full}, 128'(1));
        set_slot(0, 1, 0, 1, 0, 32'h1, 1, 0, 32'h2, 1);
        set_slot(1, 2, 0, 1, 0, 32'h3, 1, 0, 32'h4, 2);
        step("R2");
        // R5: one broadcast wakes all six; a later broadcast must not disturb ready sources
        bc_vld = 1; bc_tag = 5; bc_dat = 32'hCAFE_F00D;
        step("R5");
        bc_vld = 1; bc_tag = 5; bc_dat = 32'h0BAD_0BAD;
        step("R5 R8");
        step("R8 R9");
        step("R9");

        // R6: slot 1 only, tag broadcast in the same cycle
        set_slot(1, 33, 2, 0, 3, 32'h0, 1, 0, 32'h77, 40);
        bc_vld = 1; bc_tag = 3; bc_dat = 32'h1234_5678;
        step("R6 R3");
        step("R6");

        // R10: flush with a dispatch group present
        set_slot(0, 7, 0, 1, 0, 32'h11, 1, 0, 32'h22, 3);
        set_slot(1, 8, 1, 1, 0, 32'h33, 1, 0, 32'h44, 4);
        fu_busy = '1;
        step("R10");
        flush = 1;
        set_slot(0, 9, 2, 1, 0, 32'h55, 1, 0, 32'h66, 5);
        step("R10");
        step("R10");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            for (int k = 0; k < D; k++) begin
                if ($urandom % 2 == 0) begin
                    set_slot(k, int'($urandom % 64), int'($urandom % F),
                             bit'($urandom % 2), int'($urandom % 8), $urandom,
                             bit'($urandom % 2), int'($urandom % 8), $urandom,
                             int'($urandom % 64));
                end
            end
            bc_vld  = ($urandom % 2 == 0);
            bc_tag  = TAG_W'($urandom % 8);
            bc_dat  = $urandom;
            fu_busy = F'($urandom);
            flush   = ($urandom % 64 == 0);
            step("R5 R7 R8");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule